// File: doc/BRIEF.md
# Byte-Serial Memory Write Command Handler

This block sits between a host byte stream and a memory controller. It watches the incoming bytes for a write opcode and then gathers a frame of eight bytes: the opcode, three packed address bytes and four data bytes. It unpacks the address into row, column and bank fields and places one 32-bit write request on a request/acknowledge port. When the write has been acknowledged, it sends an eight-byte response on an outgoing byte stream.

The opcode carries the top row bit in its lowest bit. A memory-ready input flag is sampled when the last frame byte arrives. If the flag is low, the frame is still consumed and still answered, but no write is issued and the command slot of the response holds an error code. Both byte streams use valid/ready handshakes. The block accepts nothing new until the last response byte has been taken.

Top module: `memwr_cmd_handler`

## Requirements
- R1: While idle, only 0x90 and 0x91 start a frame, and bit 0 of the opcode becomes the most significant row bit (row bit 12).
- R2: The address bytes arrive most significant first and form A[23:0]. The request row is {opcode[0], A[23:12]}.
- R3: The request column is A[11:2] (10 bits) and the request bank is A[1:0].
- R4: The request data is {D3, D2, D1, D0}, where D0 is the first data byte received, so D0 sits in bits 7:0.
- R5: When memory is ready, each frame raises the request exactly once. Request and fields hold steady until the acknowledge, and the request drops in the cycle after it.
- R6: The response is D0, D1, D2, D3, the opcode, then A[23:16], A[15:8], A[7:0].
- R7: If the ready flag is low when the last frame byte is accepted, no request is raised and the opcode slot of the response holds 0xE7. The other seven response bytes are unchanged.
- R8: Bytes other than 0x90/0x91 seen while idle are dropped. They raise no request and produce no response.
- R9: in_ready_o stays low from the cycle after the last frame byte until the last response byte has been taken.
- R10: While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o hold their values.
- R11: Synchronous reset returns the block to idle with in_ready_o high, out_valid_o and mem_req_o low, and any partly collected frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Incoming byte valid |
| in_data_i | input | 8 | Incoming byte |
| in_ready_o | output | 1 | Block can take an incoming byte |
| out_valid_o | output | 1 | Response byte valid |
| out_data_o | output | 8 | Response byte |
| out_ready_i | input | 1 | Downstream takes the response byte |
| mem_init_i | input | 1 | Memory has been initialised |
| mem_req_o | output | 1 | Write request |
| mem_ack_i | input | 1 | Write acknowledge |
| mem_row_o | output | 13 | Row address |
| mem_col_o | output | 10 | Column address |
| mem_bank_o | output | 2 | Bank address |
| mem_data_o | output | 32 | Write data, first byte in bits 7:0 |

## Verification
The assertions assume that the acknowledge is a one-cycle pulse that appears only while the request is high. They also assume that the downstream ready may toggle freely, so stalls at any point in the response must be tolerated. The bench's memory model raises the acknowledge only in reply to a visible request, after a delay of zero to three cycles, and then drops it. The output sink drives ready from either a constant or a pseudo-random pattern. The input driver holds each byte until it is taken, so every handshake the checker sees is a legal one.

// File: rtl/memwr_pkg.sv
package memwr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] OPC_MATCH = 8'h90;
  localparam logic [7:0] OPC_MASK  = 8'hFE;
  localparam logic [7:0] ERR_CODE  = 8'hE7;

  typedef enum logic [1:0] {RX_IDLE, RX_BODY, RX_HELD} rx_state_e;
endpackage

// File: rtl/memwr_frame_rx.sv
module memwr_frame_rx
  import memwr_pkg::*;
#(
  parameter int FRAME_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid_i,
  input  logic [BYTE_W-1:0]             in_data_i,
  output logic                          in_ready_o,
  input  logic                          mem_init_i,
  input  logic                          release_i,
  output logic [FRAME_BYTES*BYTE_W-1:0] frame_o,
  output logic                          done_o,
  output logic                          init_ok_o
);
  localparam int CNT_W = $clog2(FRAME_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BYTES - 1);

  rx_state_e                      state_q;
  logic [CNT_W-1:0]               cnt_q;
  logic [FRAME_BYTES*BYTE_W-1:0]  frame_q;
  logic                           accept;

  assign in_ready_o = (state_q != RX_HELD);
  assign accept     = in_valid_i && in_ready_o;
  assign frame_o    = frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      frame_q   <= '0;
      done_o    <= 1'b0;
      init_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (accept && ((in_data_i & OPC_MASK) == OPC_MATCH)) begin
            frame_q[BYTE_W-1:0] <= in_data_i;
            cnt_q               <= CNT_W'(1);
            state_q             <= RX_BODY;
          end
        end
        RX_BODY: begin
          if (accept) begin
            frame_q[cnt_q*BYTE_W +: BYTE_W] <= in_data_i;
            if (cnt_q == LAST) begin
              state_q   <= RX_HELD;
              done_o    <= 1'b1;
              init_ok_o <= mem_init_i;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          if (release_i) state_q <= RX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/memwr_mem_issue.sv
module memwr_mem_issue
  import memwr_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int DATA_BYTES = 4,
  parameter int COL_W      = 10,
  parameter int BANK_W     = 2,
  localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
  localparam int DATA_W    = DATA_BYTES * BYTE_W,
  localparam int ROW_W     = ADDR_W - COL_W - BANK_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 top_row_i,
  input  logic [ADDR_W+DATA_W-1:0] body_i,
  output logic                 req_o,
  input  logic                 ack_i,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [DATA_W-1:0]    data_o,
  output logic                 done_o
);
  logic [ADDR_W-1:0] addr_w;
  logic [DATA_W-1:0] data_w;

  // body byte 0 is the most significant address byte
  for (genvar j = 0; j < ADDR_BYTES; j++) begin : g_addr
    assign addr_w[(ADDR_BYTES-1-j)*BYTE_W +: BYTE_W] = body_i[j*BYTE_W +: BYTE_W];
  end
  assign data_w = body_i[ADDR_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      done_o <= 1'b0;
      row_o  <= '0;
      col_o  <= '0;
      bank_o <= '0;
      data_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        req_o  <= 1'b1;
        row_o  <= {top_row_i, addr_w[ADDR_W-1 -: ROW_W-1]};
        col_o  <= addr_w[BANK_W +: COL_W];
        bank_o <= addr_w[BANK_W-1:0];
        data_o <= data_w;
      end else if (req_o && ack_i) begin
        req_o  <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/memwr_resp_tx.sv
module memwr_resp_tx
  import memwr_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int DATA_BYTES = 4,
  localparam int FRAME_BYTES = 1 + ADDR_BYTES + DATA_BYTES,
  localparam int FRAME_W     = FRAME_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              err_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              release_o
);
  localparam int ADDR_W = ADDR_BYTES * BYTE_W;
  localparam int DATA_W = DATA_BYTES * BYTE_W;
  localparam int CNT_W  = $clog2(FRAME_BYTES);

  logic [FRAME_W-1:0] load_w;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               take;

  // response order: data bytes, command slot, address bytes
  assign load_w[0 +: DATA_W]               = frame_i[(1+ADDR_BYTES)*BYTE_W +: DATA_W];
  assign load_w[DATA_W +: BYTE_W]          = err_i ? ERR_CODE : frame_i[BYTE_W-1:0];
  assign load_w[DATA_W+BYTE_W +: ADDR_W]   = frame_i[BYTE_W +: ADDR_W];

  assign take       = out_valid_o && out_ready_i;
  assign release_o  = take && (left_q == '0);
  assign out_data_o = sh_q[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      sh_q        <= '0;
      left_q      <= '0;
    end else if (start_i) begin
      out_valid_o <= 1'b1;
      sh_q        <= load_w;
      left_q      <= CNT_W'(FRAME_BYTES - 1);
    end else if (take) begin
      sh_q <= sh_q >> BYTE_W;
      if (left_q == '0) out_valid_o <= 1'b0;
      else              left_q      <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/memwr_cmd_handler.sv
module memwr_cmd_handler
  import memwr_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int DATA_BYTES = 4,
  parameter int COL_W      = 10,
  parameter int BANK_W     = 2,
  localparam int ADDR_W      = ADDR_BYTES * BYTE_W,
  localparam int DATA_W      = DATA_BYTES * BYTE_W,
  localparam int ROW_W       = ADDR_W - COL_W - BANK_W + 1,
  localparam int FRAME_BYTES = 1 + ADDR_BYTES + DATA_BYTES,
  localparam int FRAME_W     = FRAME_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  input  logic              out_ready_i,
  input  logic              mem_init_i,
  output logic              mem_req_o,
  input  logic              mem_ack_i,
  output logic [ROW_W-1:0]  mem_row_o,
  output logic [COL_W-1:0]  mem_col_o,
  output logic [BANK_W-1:0] mem_bank_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [FRAME_W-1:0] frame_w;
  logic rx_done, rx_init_ok, wr_done, tx_release;
  logic issue_start, tx_start;

  assign issue_start = rx_done && rx_init_ok;
  assign tx_start    = (rx_done && !rx_init_ok) || wr_done;

  memwr_frame_rx #(.FRAME_BYTES(FRAME_BYTES)) rx_i (
    .clk(clk), .rst(rst),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .mem_init_i(mem_init_i), .release_i(tx_release),
    .frame_o(frame_w), .done_o(rx_done), .init_ok_o(rx_init_ok)
  );

  memwr_mem_issue #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES),
                    .COL_W(COL_W), .BANK_W(BANK_W)) issue_i (
    .clk(clk), .rst(rst), .start_i(issue_start),
    .top_row_i(frame_w[0]), .body_i(frame_w[FRAME_W-1:BYTE_W]),
    .req_o(mem_req_o), .ack_i(mem_ack_i),
    .row_o(mem_row_o), .col_o(mem_col_o), .bank_o(mem_bank_o),
    .data_o(mem_data_o), .done_o(wr_done)
  );

  memwr_resp_tx #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) tx_i (
    .clk(clk), .rst(rst), .start_i(tx_start), .err_i(!rx_init_ok),
    .frame_i(frame_w), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready_i), .release_o(tx_release)
  );
endmodule

// File: rtl/memwr_cmd_handler_chk.sv
module memwr_cmd_handler_chk #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [7:0]        out_data_o,
  input logic              out_ready_i,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [ROW_W-1:0]  mem_row_o,
  input logic [COL_W-1:0]  mem_col_o,
  input logic [BANK_W-1:0] mem_bank_o,
  input logic [DATA_W-1:0] mem_data_o
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o);
  // R5
  req_fields_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> $stable(mem_row_o) && $stable(mem_col_o)
                                && $stable(mem_bank_o) && $stable(mem_data_o));
  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_ack_i |=> !mem_req_o);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  // R9
  in_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o || mem_req_o) |-> !in_ready_o);
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid_o && mem_req_o));
endmodule

bind memwr_cmd_handler memwr_cmd_handler_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
  .out_data_o(out_data_o), .out_ready_i(out_ready_i), .mem_req_o(mem_req_o),
  .mem_ack_i(mem_ack_i), .mem_row_o(mem_row_o), .mem_col_o(mem_col_o),
  .mem_bank_o(mem_bank_o), .mem_data_o(mem_data_o)
);

// File: tb/memwr_cmd_handler_tb_top.sv
`timescale 1ns/1ps
module memwr_cmd_handler_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_ready = 1'b0, mem_init = 1'b1;
  logic [7:0] out_data;
  logic mem_req, mem_ack = 1'b0;
  logic [12:0] mem_row;
  logic [9:0]  mem_col;
  logic [1:0]  mem_bank;
  logic [31:0] mem_data;

  always #2.5 clk = ~clk;

  memwr_cmd_handler dut_i (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready), .mem_init_i(mem_init), .mem_req_o(mem_req),
    .mem_ack_i(mem_ack), .mem_row_o(mem_row), .mem_col_o(mem_col),
    .mem_bank_o(mem_bank), .mem_data_o(mem_data)
  );

  int vectors = 0, miscompares = 0;
  int mode = 0;            // 0: no stalls, 1/2: pseudo-random stalls
  logic [15:0] lfsr = 16'hACE1;
  int wr_cnt = 0, rsp_n = 0, ack_wait = 0, cycles = 0, blk_err = 0;
  logic [12:0] cap_row; logic [9:0] cap_col; logic [1:0] cap_bank; logic [31:0] cap_data;
  logic [7:0] rsp [0:1023];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      vectors++; miscompares++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      finish_run();
    end
  end

  // memory model and output sink, acting at the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst) begin
      mem_ack = 1'b0; ack_wait = 0;
    end else begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (ack_wait == 0) begin
          mem_ack = 1'b1; wr_cnt++;
          cap_row = mem_row; cap_col = mem_col; cap_bank = mem_bank; cap_data = mem_data;
          ack_wait = (mode == 0) ? 0 : int'(lfsr[1:0]);
        end else ack_wait--;
      end
    end
    out_ready = (mode == 0) ? 1'b1 : (mode == 1 ? lfsr[3] : (lfsr[5] | lfsr[2]));
    if (!rst && out_valid && out_ready) begin
      rsp[rsp_n[9:0]] = out_data; rsp_n++;
    end
    if (!rst && out_valid && in_ready) blk_err++;
  end

  task automatic put_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [23:0] addr,
                         input logic [31:0] data, input bit init, input int md);
    int wr0, n0, b0;
    logic [7:0] exp_rsp [0:7];
    mode = md; mem_init = init;
    wr0 = wr_cnt; n0 = rsp_n; b0 = blk_err;
    put_byte(op);
    put_byte(addr[23:16]); put_byte(addr[15:8]); put_byte(addr[7:0]);
    for (int k = 0; k < 4; k++) put_byte(data[8*k +: 8]);
    while (rsp_n < n0 + 8) @(negedge clk);
    repeat (3) @(negedge clk);
    if (init) begin
      chk(wr_cnt == wr0 + 1, "R5 one write", wr_cnt - wr0, 1);
      // R1 R2: row = {op[0], A[23:12]}
      chk(cap_row == 13'(((op & 8'h01) << 12) | (addr >> 12)), "R2 row", cap_row,
          ((op & 8'h01) << 12) | (addr >> 12));
      chk(cap_row[12] == op[0], "R1 top row bit", cap_row[12], op[0]);
      chk(cap_col == 10'((addr >> 2) & 24'h3FF), "R3 column", cap_col, (addr >> 2) & 24'h3FF);
      chk(cap_bank == 2'(addr % 4), "R3 bank", cap_bank, addr % 4);
      chk(cap_data == data, "R4 data", cap_data, data);
    end else begin
      chk(wr_cnt == wr0, "R7 no write", wr_cnt - wr0, 0);
    end
    chk(rsp_n == n0 + 8, "R6 response length", rsp_n - n0, 8);
    chk(blk_err == b0, "R9 input blocked", blk_err - b0, 0);
    for (int k = 0; k < 4; k++) exp_rsp[k] = data[8*k +: 8];
    exp_rsp[4] = init ? op : 8'hE7;
    exp_rsp[5] = addr[23:16]; exp_rsp[6] = addr[15:8]; exp_rsp[7] = addr[7:0];
    for (int k = 0; k < 8; k++) begin
      if (k == 4) chk(rsp[(n0+k) % 1024] == exp_rsp[k], init ? "R6 cmd echo" : "R7 error code",
                      rsp[(n0+k) % 1024], exp_rsp[k]);
      else chk(rsp[(n0+k) % 1024] == exp_rsp[k], "R6 echo byte", rsp[(n0+k) % 1024], exp_rsp[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
    chk(mem_req == 1'b0, "R11 mem_req after reset", mem_req, 0);
    rst = 1'b0;
    @(negedge clk);

    // edge addresses
    run_cmd(8'h90, 24'h000000, 32'h00000000, 1, 0);
    run_cmd(8'h91, 24'hFFFFFF, 32'hFFFFFFFF, 1, 0);
    run_cmd(8'h91, 24'hFFFFFF, 32'h01234567, 0, 1);

    // R8 stray bytes while idle
    begin
      int wr0, n0;
      wr0 = wr_cnt; n0 = rsp_n;
      put_byte(8'h92); put_byte(8'h00); put_byte(8'hE7); put_byte(8'h8F); put_byte(8'h10);
      repeat (20) @(negedge clk);
      chk(wr_cnt == wr0, "R8 stray no write", wr_cnt - wr0, 0);
      chk(rsp_n == n0, "R8 stray no response", rsp_n - n0, 0);
      chk(in_ready == 1'b1, "R8 still idle", in_ready, 1);
    end
    run_cmd(8'h90, 24'h5A5A5A, 32'hCAFEF00D, 1, 2);

    // R11 reset during a partial frame
    put_byte(8'h91); put_byte(8'hAA); put_byte(8'hBB);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk(in_ready == 1'b1, "R11 idle after mid-frame reset", in_ready, 1);
    run_cmd(8'h90, 24'h123456, 32'h89ABCDEF, 1, 0);

    // sweep over address patterns, opcodes, ready flag and stall modes
    for (int i = 0; i < 64; i++) begin
      logic [23:0] a;
      logic [31:0] d;
      a = 24'((i * 32'h02A5F3 + 32'h13579B) ^ (i << 20));
      d = (i * 32'h01010101) ^ 32'hA5C35A3C;
      run_cmd(8'h90 | 8'(i & 1), a, d, (i % 6) != 5, i % 3);
    end
    finish_run();
  end
endmodule